// File: doc/BRIEF.md
# Multiplexed ADC Acquisition Sequencer

This block is the control core of a multiplexed analog front end that has a programmable-gain stage and a 16-bit converter. Software writes a control word to pick an input channel, single-ended or differential wiring, and a gain code. The block drives those choices to the analog side. Every control write starts a fixed settling interval, timed by a down-counter whose length is a parameter (10 µs expressed in clock cycles).

Conversions run on an abstract converter port made of a start pulse, a busy input and a data input. Two control bits select one of four modes.

- **Automatic mode:** the conversion fires by itself once settling ends.
- **Normal mode:** software starts each conversion by writing the convert-start address. In this mode a new channel may be selected while a conversion runs, so its settling overlaps that conversion.
- **Pipeline mode:** when conversion N starts, the data register receives the result of conversion N-1.
- **Non-pipelined mode:** the data register receives conversion N's own result when that conversion ends.

A status byte shows the settle-busy and ADC-busy flags. Two interrupt pulses mark the end of settling and the end of a conversion.

Top module: `mxadc_sequencer`

## Requirements
- R1: Register map on the 2-bit bus address: 0 is the control word, 1 is the data register (read), 2 is the status byte (read), 3 is convert-start (write). Control bits 3:0 hold the channel, bit 4 selects differential mode (1 = differential), bits 6:5 hold the gain code, bit 7 enables automatic mode, bit 8 enables pipeline mode and bit 9 enables interrupts. Control bits 15:10 read as zero, and writes to them are ignored.
- R2: `gain_sel` and `diff_sel` follow the stored control word. `mux_sel` follows the channel field, except that in differential mode bit 3 of `mux_sel` is forced to 0, so only channels 0 to 7 are selected.
- R3: A control write sets status bit 0 (settle busy) for exactly SETTLE_CYCLES clock cycles, counted from the write edge. Status bits 7:2 read as zero.
- R4: In automatic mode, a control write alone produces exactly one start pulse. That pulse is issued only after settling has ended. Status bit 1 (ADC busy) reads 1 from the write, through settling and the conversion, until the converter has finished.
- R5: In normal mode, a start pulse is issued only after a write to convert-start. The written value does not matter. A control write alone never starts a conversion.
- R6: A convert-start write made while ADC busy is 1 is ignored: no extra start pulse is issued, and the data register is unchanged.
- R7: In normal mode, a control write during a running conversion updates the analog selects and starts settling at once. The running conversion completes normally.
- R8: With pipeline disabled, the data register holds the result of conversion N once ADC busy falls. The data register does not change while ADC busy stays 0.
- R9: With pipeline enabled, the data register receives the result of conversion N-1 when conversion N starts. The first conversion after reset yields 0.
- R10: With interrupts enabled, `irq_done` pulses for one cycle at the end of every conversion. `irq_settle` pulses at the end of settling only in normal mode.
- R11: After reset, the control word, data register and status all read 0. All select outputs, `cnv_start` and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is zero when low |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| mux_sel | output | 4 | Input multiplexer channel select |
| diff_sel | output | 1 | 1 = differential input wiring |
| gain_sel | output | 2 | Amplifier gain code |
| cnv_start | output | 1 | One-cycle conversion start pulse |
| cnv_busy | input | 1 | Converter busy |
| cnv_data | input | 16 | Converter result, valid when busy falls |
| irq_settle | output | 1 | Settling-done interrupt pulse |
| irq_done | output | 1 | Conversion-done interrupt pulse |

## Verification
The sequencer is exercised with each combination of the automatic and pipeline bits. Each mode is judged by when start pulses appear and by which converter result lands in the data register, so pipelined and direct loading are told apart by their different values. Convert-start writes are issued back to back, and during a conversion, to separate accepted starts from ignored ones. A control write placed during a conversion shows that settling overlaps the conversion without disturbing it. Cycle-exact status reads at the end of settling pin the interval length, and a differential control word with channel bit 3 set shows the channel masking.

// File: rtl/mxadc_pkg.sv
// Package: shared types and field positions for the ADC acquisition sequencer.
// Assumes a 10-bit control field inside a wider bus word.
package mxadc_pkg;

    localparam int CTRL_W = 10;
    localparam int B_AUTO = 7;

    // Control word, MSB first: irq enable at bit 9 down to channel at bits 3:0.
    typedef struct packed {
        logic       irq_en;
        logic       pipe_en;
        logic       auto_en;
        logic [1:0] gain;
        logic       diff;
        logic [3:0] chan;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_STAT = 2'd2,
        REG_CONV = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        CV_IDLE  = 2'd0,
        CV_START = 2'd1,
        CV_WAIT  = 2'd2,
        CV_RUN   = 2'd3
    } conv_state_e;

endpackage

// File: rtl/mxadc_regs.sv
// Module: register file and bus decode.
// Holds the control word (masked to its defined bits) and decodes write strobes.
// Returns read data combinationally, and zero when no read strobe is present.
// Assumes single-cycle write strobes and DATA_W >= CTRL_W.
module mxadc_regs
    import mxadc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] data_reg,
    input  logic              settle_busy,
    input  logic              adc_busy,
    output ctrl_t             ctrl,
    output logic              new_auto,
    output logic              ctrl_wr,
    output logic              conv_wr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((64'd1 << CTRL_W) - 64'd1);
    localparam int STAT_W = 8;

    logic [DATA_W-1:0] ctrl_q;
    logic [STAT_W-1:0] status;

    // Decode the two write targets.
    always_comb begin
        ctrl_wr  = wr && (reg_addr_e'(addr) == REG_CTRL);
        conv_wr  = wr && (reg_addr_e'(addr) == REG_CONV);
        new_auto = wdata[B_AUTO];
    end

    // Store the control word; undefined bits are forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata & CTRL_MASK;
    end

    assign ctrl   = ctrl_t'(ctrl_q[CTRL_W-1:0]);
    assign status = {{(STAT_W-2){1'b0}}, adc_busy, settle_busy};

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (reg_addr_e'(addr))
                REG_CTRL: rdata = ctrl_q;
                REG_DATA: rdata = data_reg;
                REG_STAT: rdata = DATA_W'(status);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mxadc_settle.sv
// Module: settling interval timer.
// A down-counter is reloaded with SETTLE_CYCLES by every control write.
// busy is high while the count is non-zero. expire is high in the last busy
// cycle, unless a reload arrives in that same cycle.
// Assumes SETTLE_CYCLES >= 1.
module mxadc_settle #(
    parameter int SETTLE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic expire
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Reload on a control write, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= CNT_W'(SETTLE_CYCLES);
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign busy   = (cnt != '0);
    assign expire = !load && (cnt == CNT_W'(1));

endmodule

// File: rtl/mxadc_conv.sv
// Module: conversion sequencer.
// Issues the start pulse, follows the converter busy handshake and loads the
// data register according to the pipeline rule.
// Assumes the converter raises busy some cycles after start and presents its
// result on the data input while busy falls.
module mxadc_conv
    import mxadc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              new_auto,
    input  logic              conv_wr,
    input  logic              auto_en,
    input  logic              pipe_en,
    input  logic              irq_en,
    input  logic              settle_busy,
    input  logic              cnv_busy,
    input  logic [DATA_W-1:0] cnv_data,
    output logic              cnv_start,
    output logic              adc_busy,
    output logic [DATA_W-1:0] data_reg,
    output logic              irq_done
);

    conv_state_e       state;
    logic              pending;
    logic              pipe_q;
    logic [DATA_W-1:0] last_res;
    logic              go_auto, go_norm, go, finish;

    // Start conditions for both modes and the end-of-conversion event.
    always_comb begin
        go_auto = pending && !settle_busy && (state == CV_IDLE) && !ctrl_wr;
        go_norm = conv_wr && !auto_en && !pending && (state == CV_IDLE);
        go      = go_auto || go_norm;
        finish  = (state == CV_RUN) && !cnv_busy;
    end

    // An automatic-mode control write arms a pending start; a normal write disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (ctrl_wr) pending <= new_auto;
        else if (go_auto) pending <= 1'b0;
    end

    // Handshake state machine with the converter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CV_IDLE;
        end else begin
            case (state)
                CV_IDLE:  if (go) state <= CV_START;
                CV_START: state <= CV_WAIT;
                CV_WAIT:  if (cnv_busy) state <= CV_RUN;
                CV_RUN:   if (!cnv_busy) state <= CV_IDLE;
                default:  state <= CV_IDLE;
            endcase
        end
    end

    // Latch the pipeline choice at the start; load the data register per that rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q   <= 1'b0;
            last_res <= '0;
            data_reg <= '0;
        end else if (go) begin
            pipe_q <= pipe_en;
            if (pipe_en) data_reg <= last_res;
        end else if (finish) begin
            last_res <= cnv_data;
            if (!pipe_q) data_reg <= cnv_data;
        end
    end

    // One-cycle conversion-done interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_done <= 1'b0;
        else        irq_done <= finish && irq_en;
    end

    assign cnv_start = (state == CV_START);
    assign adc_busy  = pending || (state != CV_IDLE);

endmodule

// File: rtl/mxadc_sequencer.sv
// Module: top of the multiplexed ADC acquisition sequencer.
// Wires the register file, the settling timer and the conversion sequencer.
// Drives the analog select lines and the settling interrupt.
// SETTLE_CYCLES is the settling time divided by the clock period.
module mxadc_sequencer
    import mxadc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1000,
    parameter int DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [3:0]        mux_sel,
    output logic              diff_sel,
    output logic [1:0]        gain_sel,
    output logic              cnv_start,
    input  logic              cnv_busy,
    input  logic [DATA_W-1:0] cnv_data,
    output logic              irq_settle,
    output logic              irq_done
);

    ctrl_t             ctrl;
    logic              new_auto, ctrl_wr, conv_wr;
    logic              settle_busy, settle_expire, adc_busy;
    logic [DATA_W-1:0] data_reg;

    mxadc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .wdata      (bus_wdata),
        .data_reg   (data_reg),
        .settle_busy(settle_busy),
        .adc_busy   (adc_busy),
        .ctrl       (ctrl),
        .new_auto   (new_auto),
        .ctrl_wr    (ctrl_wr),
        .conv_wr    (conv_wr),
        .rdata      (bus_rdata)
    );

    mxadc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctrl_wr),
        .busy  (settle_busy),
        .expire(settle_expire)
    );

    mxadc_conv #(.DATA_W(DATA_W)) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .new_auto   (new_auto),
        .conv_wr    (conv_wr),
        .auto_en    (ctrl.auto_en),
        .pipe_en    (ctrl.pipe_en),
        .irq_en     (ctrl.irq_en),
        .settle_busy(settle_busy),
        .cnv_busy   (cnv_busy),
        .cnv_data   (cnv_data),
        .cnv_start  (cnv_start),
        .adc_busy   (adc_busy),
        .data_reg   (data_reg),
        .irq_done   (irq_done)
    );

    // Analog selects; differential mode allows only the lower eight channels.
    always_comb begin
        mux_sel  = {ctrl.chan[3] & ~ctrl.diff, ctrl.chan[2:0]};
        diff_sel = ctrl.diff;
        gain_sel = ctrl.gain;
    end

    // Settling-done interrupt, raised in normal mode only.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_settle <= 1'b0;
        else        irq_settle <= settle_expire && ctrl.irq_en && !ctrl.auto_en;
    end

endmodule

// File: rtl/mxadc_sequencer_chk.sv
// Module: assertion checker for the sequencer, bound to the top module.
// Observes internal status flags and the converter handshake.
module mxadc_sequencer_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              cnv_start,
    input logic              cnv_busy,
    input logic              settle_busy,
    input logic              adc_busy,
    input logic              auto_en,
    input logic              irq_settle,
    input logic [DATA_W-1:0] data_reg
);

    // R3: a control write always opens a settling interval.
    p_settle_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> settle_busy);

    // R4: the start request is a single-cycle pulse.
    p_single_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    // R4: in automatic mode, ADC busy covers the settling interval.
    p_auto_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_busy && auto_en) |-> adc_busy);

    // R6: no start while the converter is busy.
    p_no_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_busy |-> !cnv_start);

    // R8: the data register is quiet while ADC busy stays low.
    p_data_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_busy && $past(!adc_busy)) |-> $stable(data_reg));

    // R10: the settling interrupt appears only in normal mode, after settling ends.
    p_irq_settle_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_settle |-> (!auto_en && !settle_busy));

endmodule

bind mxadc_sequencer mxadc_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .cnv_start  (cnv_start),
    .cnv_busy   (cnv_busy),
    .settle_busy(settle_busy),
    .adc_busy   (adc_busy),
    .auto_en    (ctrl.auto_en),
    .irq_settle (irq_settle),
    .data_reg   (data_reg)
);

// File: tb/mxadc_sequencer_bench.sv
// Directed bench for the sequencer, with a behavioural converter model.
module mxadc_sequencer_bench;

    localparam int S    = 20;
    localparam int CONV = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  mux_sel;
    logic        diff_sel;
    logic [1:0]  gain_sel;
    logic        cnv_start;
    logic        cnv_busy;
    logic [15:0] cnv_data;
    logic        irq_settle, irq_done;

    int checks = 0, fails = 0;
    int m_n = 0;
    int m_cnt = 0;
    int n_is = 0, n_id = 0;
    logic m_busy = 1'b0;
    logic [15:0] m_data = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mxadc_sequencer #(.SETTLE_CYCLES(S), .DATA_W(16)) u_mxadc_sequencer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mux_sel(mux_sel), .diff_sel(diff_sel), .gain_sel(gain_sel),
        .cnv_start(cnv_start), .cnv_busy(cnv_busy), .cnv_data(cnv_data),
        .irq_settle(irq_settle), .irq_done(irq_done)
    );

    assign cnv_busy = m_busy;
    assign cnv_data = m_data;

    function automatic logic [15:0] res(int k);
        return 16'h4000 + 16'(k * 16'h0123);
    endfunction

    // Converter model: fixed busy time, then result k for the k-th start.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_cnt  <= 0;
        end else if (cnv_start && !m_busy) begin
            m_busy <= 1'b1;
            m_cnt  <= CONV;
            m_data <= res(m_n + 1);
            m_n    <= m_n + 1;
        end else if (m_busy) begin
            if (m_cnt == 1) m_busy <= 1'b0;
            m_cnt <= m_cnt - 1;
        end
    end

    always @(posedge clk) begin
        if (irq_settle) n_is <= n_is + 1;
        if (irq_done)   n_id <= n_id + 1;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] st;
        bit idle = 1'b0;
        for (int i = 0; i < 1000 && !idle; i++) begin
            bus_read(2'd2, st);
            if (st[1:0] == 2'b00) idle = 1'b1;
        end
        if (!idle) chk("wait_idle", 32'd0, 32'd1);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R11: every register and output is clear after reset.
    task automatic t_reset();
        logic [15:0] d;
        bus_read(2'd0, d); chk("R11 ctrl", d, 0);
        bus_read(2'd1, d); chk("R11 data", d, 0);
        bus_read(2'd2, d); chk("R11 status", d, 0);
        chk("R11 outputs", {mux_sel, diff_sel, gain_sel, cnv_start, irq_settle, irq_done}, 0);
    endtask

    // R1, R2, R3, R5: field layout, selects, settling length, no start in normal mode.
    task automatic t_fields_settle();
        logic [15:0] d;
        int n0 = m_n;
        bus_write(2'd0, 16'hFC5B);
        bus_read(2'd0, d);  chk("R1 readback masks 15:10", d, 16'h005B);
        chk("R2 diff masks mux bit3", mux_sel, 4'h3);
        chk("R2 diff_sel", diff_sel, 1);
        chk("R2 gain_sel", gain_sel, 2'b10);
        bus_write(2'd0, 16'h000B);
        chk("R2 single-ended mux", mux_sel, 4'hB);
        repeat (S - 2) @(negedge clk);
        bus_read(2'd2, d);  chk("R3 settle busy last cycle", d, 16'h0001);
        bus_read(2'd2, d);  chk("R3 settle ended, bits 7:2 zero", d, 16'h0000);
        repeat (10) @(negedge clk);
        chk("R5 no start without convert write", m_n, n0);
    endtask

    // R5, R8: normal mode without pipeline.
    task automatic t_normal();
        logic [15:0] d;
        int n0 = m_n;
        bus_write(2'd3, 16'h0000);
        wait_idle();
        chk("R5 one start", m_n, n0 + 1);
        bus_read(2'd1, d); chk("R8 direct result", d, res(n0 + 1));
        repeat (5) @(negedge clk);
        bus_read(2'd1, d); chk("R8 data held while idle", d, res(n0 + 1));
    endtask

    // R6: back-to-back convert writes; the second is ignored.
    task automatic t_busy_ignore();
        logic [15:0] d;
        int n0 = m_n;
        bus_write(2'd3, 16'h1234);
        bus_write(2'd3, 16'hFFFF);
        repeat (10) @(negedge clk);
        bus_write(2'd3, 16'h0001);
        wait_idle();
        chk("R6 single start", m_n, n0 + 1);
        bus_read(2'd1, d); chk("R6 data of first only", d, res(n0 + 1));
    endtask

    // R7: control write during a conversion overlaps settling.
    task automatic t_overlap();
        logic [15:0] d;
        int n0 = m_n;
        bus_write(2'd3, 16'h0000);
        bus_write(2'd0, 16'h0005);
        bus_read(2'd2, d); chk("R7 settle and busy together", d, 16'h0003);
        chk("R7 new channel driven", mux_sel, 4'h5);
        wait_idle();
        chk("R7 conversion completed once", m_n, n0 + 1);
        bus_read(2'd1, d); chk("R7 result intact", d, res(n0 + 1));
    endtask

    // R9: pipeline, with the first conversion after reset returning zero.
    task automatic t_pipeline();
        logic [15:0] d;
        int n0;
        pulse_reset();
        n0 = m_n;
        bus_write(2'd0, 16'h0100);
        wait_idle();
        bus_write(2'd3, 16'h0000);
        wait_idle();
        bus_read(2'd1, d); chk("R9 first after reset is zero", d, 0);
        bus_write(2'd3, 16'h0000);
        wait_idle();
        bus_read(2'd1, d); chk("R9 previous result", d, res(n0 + 1));
    endtask

    // R4: automatic mode, without and with pipeline.
    task automatic t_auto();
        logic [15:0] d;
        int n0 = m_n;
        bus_write(2'd0, 16'h0086);
        bus_read(2'd2, d); chk("R4 busy during settling", d, 16'h0003);
        repeat (S - 3) @(negedge clk);
        chk("R4 no start before settling ends", m_n, n0);
        wait_idle();
        chk("R4 one automatic start", m_n, n0 + 1);
        bus_read(2'd1, d); chk("R4 auto direct result", d, res(n0 + 1));
        bus_write(2'd0, 16'h0186);
        wait_idle();
        chk("R4 auto pipeline start", m_n, n0 + 2);
        bus_read(2'd1, d); chk("R9 auto pipeline previous", d, res(n0 + 1));
    endtask

    // R10: interrupt pulses in normal and automatic modes.
    task automatic t_irq();
        int s0 = n_is, d0 = n_id;
        bus_write(2'd0, 16'h0201);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R10 settle irq normal", n_is, s0 + 1);
        bus_write(2'd3, 16'h0000);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R10 done irq normal", n_id, d0 + 1);
        bus_write(2'd0, 16'h0281);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R10 no settle irq in auto", n_is, s0 + 1);
        chk("R10 done irq auto", n_id, d0 + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields_settle();
        t_normal();
        t_busy_ignore();
        t_overlap();
        t_pipeline();
        t_auto();
        t_irq();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule